// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer behind an 8-bit successive-approximation converter with five analog inputs. It selects one input through a channel select output, and it drives a trial code into the reference DAC. It reads back one comparator bit per decision, and it settles the code by a binary search from the top bit down. Once the lowest bit is settled, the finished code goes into a result register and a single-cycle interrupt is raised. The next conversion on the same input then starts at once.

Software controls the block through two write-only registers that are also visible on output ports. The mode register holds a run bit and a 3-bit conversion-time code. The channel register picks the input. Every conversion opens with a sampling window, in which the `sample_o` output tells the analog front end to track its input. Eight equal decision slots follow, and the comparator is sampled at the end of each slot. Any accepted register write drops the conversion in progress and starts a new one on the next clock.

Top module: `adc_sar_sequencer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), mode_o reads 00h, chan_sel_o reads 0, result_o reads 00h, and irq_o and sample_o are low.
- R2: A write with reg_wr_sel = 0 loads the mode register. Bit 7 is the run bit and bits 5:3 are the time code. Bits 6, 2, 1 and 0 always read back as 0, whatever value was written to them.
- R3: A write with reg_wr_sel = 1 and a value of 0 to 4 loads the channel register. A value of 5 to 7 is ignored: chan_sel_o keeps its value and the conversion in progress finishes on its original schedule.
- R4: The conversion time in clocks is set by the time code: 000 gives 144, 001 gives 120, 010 gives 96, 100 gives 288, 101 gives 240 and 110 gives 192. With the run bit set, the first irq_o pulse appears exactly that many clocks after the clock edge that accepted the write.
- R5: The result is found MSB first. The trial code puts a 1 in the bit under test, and the bit is kept when cmp_i is 1. If a comparator returns 1 whenever the input level is at or above dac_code_o, each result equals the input level.
- R6: Conversions repeat back to back. Each irq_o pulse lasts one clock, and successive pulses are exactly one conversion time apart. result_o takes the new value on the same edge that raises irq_o.
- R7: With time code 011 or 111 the sequencer stays idle even when the run bit is set. No irq_o pulse is produced and sample_o stays low.
- R8: With the run bit clear the sequencer is idle. No irq_o pulse is produced and result_o holds its last value.
- R9: An accepted mode or channel write aborts the conversion in progress without changing result_o. The next irq_o comes exactly one conversion time after that write.
- R10: chan_sel_o follows the channel register, and results track the level on the selected channel.
- R11: sample_o is high for the first T - 8*floor(3T/32) clocks of each conversion of T clocks. For code 000 this is 40 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Register select: 0 mode, 1 channel |
| reg_wr_data | input | 8 | Write data |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| chan_sel_o | output | 3 | Selected input channel |
| dac_code_o | output | 8 | Trial code for the reference DAC |
| sample_o | output | 1 | Sampling window active |
| result_o | output | 8 | Last completed conversion result |
| irq_o | output | 1 | One-cycle pulse per completed conversion |
| mode_o | output | 8 | Mode register contents |

## Verification
A wrong slot or sampling counter moves every interrupt away from its expected cycle. The scoreboard compares each pulse against the cycle of the accepting write plus a whole number of conversion times, so the error is caught at the first completion. A wrong bit decision in the search register shows in the very first result, because each result is compared with the level the comparator model was given. Restart or idle errors show as a pulse that nothing expected, or as a result value that changed across an aborting write.

// File: rtl/adc_seq_pkg.sv
// Shared constants and helpers for the conversion sequencer.
// Assumes the time code occupies three bits of the mode register.
package adc_seq_pkg;
    localparam int          MODE_RUN_BIT  = 7;
    localparam int          MODE_CODE_LSB = 3;
    localparam logic [7:0]  MODE_WR_MASK  = 8'hB8;

    typedef enum logic {SEL_MODE = 1'b0, SEL_CHAN = 1'b1} reg_sel_e;

    // Codes with both low bits set are prohibited.
    function automatic bit code_ok(input logic [2:0] code);
        return code[1:0] != 2'b11;
    endfunction

    // Total clocks per conversion: unit * (6 - low bits), doubled by the top bit.
    function automatic int conv_clocks(input logic [2:0] code, input int unit);
        return unit * ((6 - int'(code[1:0])) << code[2]);
    endfunction

    // Decision slot length: three quarters of the budget split over the bits.
    function automatic int slot_clocks(input int total, input int bits);
        return (3 * total) / (4 * bits);
    endfunction
endpackage

// File: rtl/adc_seq_regs.sv
// Mode and channel registers with write decode.
// Produces the run qualifier, a restart strobe for accepted writes,
// and the sampling and slot lengths derived from the time code.
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NUM_CHAN  = 5,
    parameter int CHAN_W    = 3,
    parameter int RES_BITS  = 8,
    parameter int TIME_UNIT = 24,
    parameter int CNT_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    output logic [7:0]        mode_q,
    output logic [CHAN_W-1:0] chan_q,
    output logic              run,
    output logic              restart,
    output logic [CNT_W-1:0]  samp_len,
    output logic [CNT_W-1:0]  slot_len
);
    logic       chan_ok;
    logic [2:0] code;
    int         total;
    int         slot;

    assign chan_ok = wr_data < 8'(NUM_CHAN);
    assign code    = mode_q[MODE_CODE_LSB +: 3];
    assign restart = wr_en && ((wr_sel == SEL_MODE) || chan_ok);
    assign run     = mode_q[MODE_RUN_BIT] && code_ok(code);

    // Derive phase lengths from the current time code.
    always_comb begin
        total    = conv_clocks(code, TIME_UNIT);
        slot     = slot_clocks(total, RES_BITS);
        slot_len = CNT_W'(slot);
        samp_len = CNT_W'(total - RES_BITS * slot);
    end

    // Register update on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            chan_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_MODE)
                mode_q <= wr_data & MODE_WR_MASK;
            else if (chan_ok)
                chan_q <= wr_data[CHAN_W-1:0];
        end
    end

    // R2
    mode_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_MODE) |=> (mode_q & ~MODE_WR_MASK) == 8'h00);

    // R3
    chan_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CHAN && !chan_ok) |=> $stable(chan_q));
endmodule

// File: rtl/adc_seq_timer.sv
// Phase timer: a sampling window, then RES_BITS decision slots.
// Emits a decide strobe on the last clock of each slot, with the bit index.
// Assumes samp_len and slot_len are nonzero while run is high.
module adc_seq_timer #(
    parameter int RES_BITS = 8,
    parameter int CNT_W    = 9,
    parameter int IDX_W    = $clog2(RES_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] samp_len,
    input  logic [CNT_W-1:0] slot_len,
    output logic             sampling,
    output logic             decide,
    output logic [IDX_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

    logic             in_samp_q;
    logic [CNT_W-1:0] cnt_q;

    assign sampling = run && in_samp_q;
    assign decide   = run && !restart && !in_samp_q && (cnt_q == slot_len - 1'b1);

    // Step through the sampling window and the decision slots.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            in_samp_q <= 1'b1;
            cnt_q     <= '0;
            bit_idx   <= TOP_IDX;
        end else if (in_samp_q) begin
            if (cnt_q == samp_len - 1'b1) begin
                in_samp_q <= 1'b0;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (cnt_q == slot_len - 1'b1) begin
            cnt_q <= '0;
            if (bit_idx == '0) begin
                in_samp_q <= 1'b1;
                bit_idx   <= TOP_IDX;
            end else begin
                bit_idx <= bit_idx - 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (in_samp_q && cnt_q == '0 && bit_idx == TOP_IDX));
endmodule

// File: rtl/adc_seq_sar.sv
// Search register and result register.
// On each decide strobe the bit under test takes the comparator value and
// the next lower bit becomes the new trial. The last decision completes the result.
module adc_seq_sar #(
    parameter int RES_BITS = 8,
    parameter int IDX_W    = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                restart,
    input  logic                sampling,
    input  logic                decide,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                cmp,
    output logic [RES_BITS-1:0] trial,
    output logic [RES_BITS-1:0] result,
    output logic                done
);
    localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};
    localparam logic [RES_BITS-1:0] ONE      = {{(RES_BITS-1){1'b0}}, 1'b1};

    logic [RES_BITS-1:0] sar_next;

    // Settle the bit under test and place the next trial bit.
    always_comb begin
        sar_next          = trial;
        sar_next[bit_idx] = cmp;
        if (bit_idx != '0)
            sar_next[bit_idx - 1'b1] = 1'b1;
    end

    // Search, transfer and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial  <= MSB_ONLY;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (restart || !run) begin
                trial <= MSB_ONLY;
            end else if (decide) begin
                if (bit_idx == '0) begin
                    result <= sar_next;
                    trial  <= MSB_ONLY;
                    done   <= 1'b1;
                end else begin
                    trial <= sar_next;
                end
            end
        end
    end

    // R6
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R5
    trial_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sampling) |-> (trial[bit_idx] &&
            ((trial & ((ONE << bit_idx) - ONE)) == '0)));
endmodule

// File: rtl/adc_sar_sequencer.sv
// Top of the conversion sequencer: registers, phase timer and search logic.
// Assumes cmp_i is valid one clock after dac_code_o and chan_sel_o settle.
module adc_sar_sequencer #(
    parameter int NUM_CHAN  = 5,
    parameter int RES_BITS  = 8,
    parameter int TIME_UNIT = 24,
    parameter int CHAN_W    = $clog2(NUM_CHAN),
    parameter int CNT_W     = $clog2(12 * TIME_UNIT + 1),
    parameter int IDX_W     = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_wr_sel,
    input  logic [7:0]          reg_wr_data,
    input  logic                cmp_i,
    output logic [CHAN_W-1:0]   chan_sel_o,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic                sample_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                irq_o,
    output logic [7:0]          mode_o
);
    logic             run;
    logic             restart;
    logic             decide;
    logic [CNT_W-1:0] samp_len;
    logic [CNT_W-1:0] slot_len;
    logic [IDX_W-1:0] bit_idx;

    adc_seq_regs #(
        .NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W), .RES_BITS(RES_BITS),
        .TIME_UNIT(TIME_UNIT), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
        .wr_data(reg_wr_data), .mode_q(mode_o), .chan_q(chan_sel_o),
        .run(run), .restart(restart), .samp_len(samp_len), .slot_len(slot_len)
    );

    adc_seq_timer #(.RES_BITS(RES_BITS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .samp_len(samp_len), .slot_len(slot_len), .sampling(sample_o),
        .decide(decide), .bit_idx(bit_idx)
    );

    adc_seq_sar #(.RES_BITS(RES_BITS), .IDX_W(IDX_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .sampling(sample_o), .decide(decide), .bit_idx(bit_idx), .cmp(cmp_i),
        .trial(dac_code_o), .result(result_o), .done(irq_o)
    );
endmodule

// File: tb/adc_sar_sequencer_bench.sv
// Scoreboard bench: the driver queues expected results with their due cycle,
// the monitor pops one on every interrupt and compares value and timing.
module adc_sar_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_wr_sel = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic       cmp_i;
    logic [2:0] chan_sel_o;
    logic [7:0] dac_code_o;
    logic       sample_o;
    logic [7:0] result_o;
    logic       irq_o;
    logic [7:0] mode_o;

    logic [7:0] ana [5];

    typedef struct {
        logic [7:0]  val;
        int unsigned at;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    int unsigned cyc = 0;
    int unsigned wr_cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          irq_seen = 0;
    logic        irq_prev = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Comparator model: high when the selected level is at or above the trial code.
    assign cmp_i = (chan_sel_o < 3'd5) ? (ana[chan_sel_o] >= dac_code_o) : 1'b0;

    adc_sar_sequencer u_adc_sar_sequencer (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .cmp_i(cmp_i), .chan_sel_o(chan_sel_o),
        .dac_code_o(dac_code_o), .sample_o(sample_o), .result_o(result_o),
        .irq_o(irq_o), .mode_o(mode_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Register write; an aborting write discards pending expectations.
    task automatic reg_write(input logic sel, input logic [7:0] d, input bit aborts);
        reg_wr_en = 1'b1;
        reg_wr_sel = sel;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        wr_cyc = cyc;
        if (aborts) exp_q.delete();
    endtask

    task automatic push_exp(input logic [7:0] v, input int unsigned t, input int n,
                            input string req);
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.val = v;
            e.at  = wr_cyc + t * k;
            e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: score each interrupt against the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_o) begin
                irq_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7/R8", "unexpected irq", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(result_o == e.val, e.req, "result", int'(result_o), int'(e.val));
                    chk(cyc == e.at, "R4/R6", "irq cycle", int'(cyc), int'(e.at));
                end
            end
            if (irq_o && irq_prev) chk(1'b0, "R6", "irq wider than one clock", 2, 1);
            irq_prev <= irq_o;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "timeout", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int codes [6] = '{0, 1, 2, 4, 5, 6};
        int tclk  [6] = '{144, 120, 96, 288, 240, 192};
        logic [7:0] lv [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        int n;
        int base;
        logic [7:0] held;

        ana[0] = 8'h11; ana[1] = 8'h22; ana[2] = 8'hA5; ana[3] = 8'h5A; ana[4] = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(mode_o == 8'h00, "R1", "mode", int'(mode_o), 0);
        chk(chan_sel_o == 3'd0, "R1", "channel", int'(chan_sel_o), 0);
        chk(result_o == 8'h00, "R1", "result", int'(result_o), 0);
        chk(!irq_o && !sample_o, "R1", "irq/sample", int'({irq_o, sample_o}), 0);

        // R2, R11, R5: junk in fixed bits, code 000 on channel 2.
        reg_write(1'b1, 8'd2, 1'b1);
        chk(chan_sel_o == 3'd2, "R10", "channel", int'(chan_sel_o), 2);
        reg_write(1'b0, 8'hC7, 1'b1);
        push_exp(8'hA5, 144, 3, "R5");
        chk(mode_o == 8'h80, "R2", "mode readback", int'(mode_o), 8'h80);
        n = 0;
        while (sample_o) begin n++; @(negedge clk); end
        chk(n == 40, "R11", "sampling clocks", n, 40);
        drain();

        // R4, R6, R10: every valid code, varied channels and levels.
        for (int i = 0; i < 6; i++) begin
            ana[i % 5] = lv[i];
            reg_write(1'b1, 8'(i % 5), 1'b1);
            reg_write(1'b0, 8'h80 | 8'(codes[i] << 3), 1'b1);
            push_exp(lv[i], tclk[i], 2, "R10");
            drain();
        end

        // R3: invalid channel mid-conversion is ignored, schedule unchanged.
        ana[4] = 8'h3C;
        reg_write(1'b1, 8'd4, 1'b1);
        reg_write(1'b0, 8'h88, 1'b1);
        push_exp(8'h3C, 120, 2, "R3");
        repeat (30) @(negedge clk);
        reg_write(1'b1, 8'd7, 1'b0);
        chk(chan_sel_o == 3'd4, "R3", "channel after value 7", int'(chan_sel_o), 4);
        drain();

        // R9: abort after 50 clocks keeps result, new result one period later.
        ana[3] = 8'h5A;
        reg_write(1'b1, 8'd3, 1'b1);
        reg_write(1'b0, 8'h90, 1'b1);
        push_exp(8'h5A, 96, 1, "R9");
        drain();
        repeat (50) @(negedge clk);
        ana[3] = 8'hC3;
        reg_write(1'b0, 8'h90, 1'b1);
        chk(result_o == 8'h5A, "R9", "result after abort", int'(result_o), 8'h5A);
        push_exp(8'hC3, 96, 1, "R9");
        drain();

        // R7: prohibited codes stay idle.
        for (int c = 0; c < 2; c++) begin
            reg_write(1'b0, (c == 0) ? 8'h98 : 8'hB8, 1'b1);
            base = irq_seen;
            n = 0;
            repeat (400) begin @(negedge clk); if (sample_o) n++; end
            chk(irq_seen == base, "R7", "irq count", irq_seen - base, 0);
            chk(n == 0, "R7", "sampling clocks", n, 0);
        end

        // R8: run bit clear, valid code.
        held = result_o;
        reg_write(1'b0, 8'h08, 1'b1);
        base = irq_seen;
        repeat (400) @(negedge clk);
        chk(irq_seen == base, "R8", "irq count", irq_seen - base, 0);
        chk(result_o == held, "R8", "result held", int'(result_o), int'(held));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule